// File: doc/BRIEF.md
# Serial Flash Block-Erase Sequencer

This block wipes a serial flash device completely, one erase block at a time, as an SPI master. A single start pulse launches the walk. For each block the sequencer lowers chip select, shifts out a 32-bit erase command that carries the block number, and raises chip select, which is the moment the device begins erasing. It then watches the device's ready/busy pin and only issues the next block's command once the device reports ready again. After the final block has finished, it pulses a done output.

When a walk is accepted, a one-clock restart pulse tells the downstream recorder that memory is blank and that writing should resume at page 0, byte 0. The SPI shifter is part of the block. It runs in mode 3 with the serial clock at a fixed fraction of the system clock, which is one quarter by default.

Top module: `flash_erase_walker`

## Requirements
- R1: While reset is held, and after reset until a start is accepted, chip select and the serial clock sit high, and busy, done and restart sit low.
- R2: A start pulse seen while idle raises busy and produces exactly one clock of restart on the next clock.
- R3: Each command frame is 32 bits, sent most significant bit first. From first bit to last it is the opcode 0x50, two zero bits, the 9-bit block number, and 13 zero bits. Chip select stays low across all 32 bits and rises after the last one.
- R4: The serial clock idles high (mode 3). Each clock period is CLK_DIV system clocks: half low, then half high. The data line changes only while the serial clock is low.
- R5: Blocks are erased in ascending order from 0 to BLOCK_COUNT-1, with exactly one frame per block.
- R6: After chip select rises, no new frame starts until ready/busy is high. Ready/busy is first sampled no sooner than GUARD_CYCLES clocks after the rise.
- R7: Done goes high for exactly one clock once ready/busy returns high after the last block. Busy is low in that same clock, and no further frames follow.
- R8: Start pulses that arrive while a walk is running are ignored. They cause no extra restart and do not disturb the block order.
- R9: The MISO input has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to erase the whole device |
| rdy_i | input | 1 | Device ready/busy; high means ready |
| miso_i | input | 1 | SPI data from device (unused) |
| cs_n_o | output | 1 | SPI chip select, active low |
| sck_o | output | 1 | SPI serial clock, idles high |
| mosi_o | output | 1 | SPI data to device |
| busy_o | output | 1 | High while a walk is in progress |
| done_o | output | 1 | One-clock pulse when the last block is erased |
| restart_o | output | 1 | One-clock pulse telling the recorder to restart at address zero |

## Verification
The bench keeps the default CLK_DIV of 4, the default GUARD_CYCLES of 2 and the full 9-bit block field. It sets BLOCK_COUNT to 6, so a complete walk, including the last-block transition and the done pulse, finishes in about a thousand clocks. That leaves room to run several whole walks, each with a different ready/busy profile: random erase times, a device that never drops ready, and very long erase times. The block field stays 9 bits wide, so the bit position of every frame field is still checked against the full-size layout.

// File: rtl/erase_seq_pkg.sv
// Shared constants and types for the flash erase walker.
// Assumes: one command opcode, five sequencer states.
package erase_seq_pkg;
    localparam logic [7:0] ERASE_OPCODE = 8'h50;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_GUARD,
        ST_WAIT
    } seq_state_t;
endpackage

// File: rtl/spi_mode3_tx.sv
// Byte-wide SPI mode-3 transmitter, MSB first.
// SCK is low for the first half of each bit period and high for the second,
// so data shifts on the falling edge and is stable at the rising edge.
// Assumes: CLK_DIV is even and at least 2; load_i arrives only while idle.
module spi_mode3_tx #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [7:0] byte_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       sck_o,
    output logic       mosi_o
);
    localparam int PH_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam logic [PH_W-1:0] HALF_P = PH_W'(CLK_DIV / 2);
    localparam logic [PH_W-1:0] LAST_P = PH_W'(CLK_DIV - 1);

    logic [7:0]      shreg_q;
    logic [2:0]      bit_q;
    logic [PH_W-1:0] phase_q;
    logic            active_q;

    // Bit timing and shifting for one byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q  <= '0;
            bit_q    <= '0;
            phase_q  <= '0;
            active_q <= 1'b0;
        end else if (load_i && !active_q) begin
            shreg_q  <= byte_i;
            bit_q    <= '0;
            phase_q  <= '0;
            active_q <= 1'b1;
        end else if (active_q) begin
            if (phase_q == LAST_P) begin
                phase_q <= '0;
                if (bit_q == 3'd7) begin
                    active_q <= 1'b0;
                end else begin
                    bit_q   <= bit_q + 3'd1;
                    shreg_q <= {shreg_q[6:0], 1'b0};
                end
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

    assign busy_o = active_q;
    assign done_o = active_q && (phase_q == LAST_P) && (bit_q == 3'd7);
    assign sck_o  = !active_q || (phase_q >= HALF_P);
    assign mosi_o = shreg_q[7];

    // R4: data must hold while the serial clock stays high.
    a_r4_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_o && $past(sck_o)) |-> $stable(mosi_o));

    // R4: a new byte is never loaded in the middle of another.
    a_r4_load_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !active_q);
endmodule

// File: rtl/erase_frame_bytes.sv
// Builds the erase command frame for one block and selects one byte of it.
// Frame, MSB first: opcode, PAD_HI zero bits, block number, PAD_LO zero bits.
// Assumes: the frame width is a multiple of 8.
module erase_frame_bytes
    import erase_seq_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int PAD_HI = 2,
    parameter int PAD_LO = 13,
    localparam int FRAME_W = 8 + PAD_HI + ADDR_W + PAD_LO,
    localparam int FRAME_BYTES = FRAME_W / 8,
    localparam int IDX_W = (FRAME_BYTES > 2) ? $clog2(FRAME_BYTES) : 1
) (
    input  logic [ADDR_W-1:0] blk_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [7:0]        byte_o
);
    logic [FRAME_W-1:0] frame;
    logic [7:0]         frame_bytes [FRAME_BYTES];

    assign frame = {ERASE_OPCODE, {PAD_HI{1'b0}}, blk_i, {PAD_LO{1'b0}}};

    // Slice the frame into bytes, first byte at the top.
    for (genvar k = 0; k < FRAME_BYTES; k++) begin : g_slice
        assign frame_bytes[k] = frame[FRAME_W-1-8*k -: 8];
    end

    assign byte_o = frame_bytes[idx_i];
endmodule

// File: rtl/erase_walk_ctrl.sv
// Control state machine: walks blocks 0..BLOCK_COUNT-1. For each block it
// frames the command under chip select, waits a guard interval, then waits
// for the device to report ready.
// Assumes: tx_done_i is a single-cycle end-of-byte strobe.
module erase_walk_ctrl
    import erase_seq_pkg::*;
#(
    parameter int BLOCK_COUNT  = 512,
    parameter int ADDR_W       = 9,
    parameter int FRAME_BYTES  = 4,
    parameter int GUARD_CYCLES = 2,
    localparam int IDX_W = (FRAME_BYTES > 2) ? $clog2(FRAME_BYTES) : 1,
    localparam int G_W   = $clog2(GUARD_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rdy_i,
    input  logic              tx_done_i,
    output logic              tx_load_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [ADDR_W-1:0] blk_o,
    output logic              cs_n_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              restart_o
);
    localparam logic [ADDR_W-1:0] BLK_LAST = ADDR_W'(BLOCK_COUNT - 1);
    localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(FRAME_BYTES - 1);
    localparam logic [G_W-1:0]    G_LAST   = G_W'(GUARD_CYCLES - 1);

    seq_state_t        state_q;
    logic [ADDR_W-1:0] blk_q;
    logic [IDX_W-1:0]  idx_q;
    logic [G_W-1:0]    gcnt_q;

    // Sequence states, block/byte counters and registered strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            blk_q     <= '0;
            idx_q     <= '0;
            gcnt_q    <= '0;
            cs_n_o    <= 1'b1;
            tx_load_o <= 1'b0;
            done_o    <= 1'b0;
            restart_o <= 1'b0;
        end else begin
            tx_load_o <= 1'b0;
            done_o    <= 1'b0;
            restart_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        restart_o <= 1'b1;
                        blk_q     <= '0;
                        idx_q     <= '0;
                        cs_n_o    <= 1'b0;
                        state_q   <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    tx_load_o <= 1'b1;
                    state_q   <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (tx_done_i) begin
                        if (idx_q == IDX_LAST) begin
                            cs_n_o  <= 1'b1;
                            gcnt_q  <= '0;
                            state_q <= ST_GUARD;
                        end else begin
                            idx_q   <= idx_q + 1'b1;
                            state_q <= ST_LOAD;
                        end
                    end
                end
                ST_GUARD: begin
                    if (gcnt_q == G_LAST) begin
                        state_q <= ST_WAIT;
                    end else begin
                        gcnt_q <= gcnt_q + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (rdy_i) begin
                        if (blk_q == BLK_LAST) begin
                            done_o  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            blk_q   <= blk_q + 1'b1;
                            idx_q   <= '0;
                            cs_n_o  <= 1'b0;
                            state_q <= ST_LOAD;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (state_q != ST_IDLE);
    assign idx_o  = idx_q;
    assign blk_o  = blk_q;

    // R6: a following frame opens only after the device reported ready.
    a_r6_ready_before_next: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n_o) && $past(state_q == ST_WAIT)) |-> $past(rdy_i));

    // R7: the done strobe lasts a single clock.
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: done follows completion of the final block only.
    a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(blk_q) == BLK_LAST) && !busy_o);

    // R8: restart is issued only from the idle state.
    a_r8_restart_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |-> $past(state_q == ST_IDLE));
endmodule

// File: rtl/flash_erase_walker.sv
// Top: whole-device serial flash erase over SPI mode 3, gated by the
// device's ready/busy pin. Ties the controller, frame builder and shifter.
// Assumes: rdy_i is synchronous to clk; MISO carries nothing needed here.
module flash_erase_walker
    import erase_seq_pkg::*;
#(
    parameter int BLOCK_COUNT  = 512,
    parameter int ADDR_W       = 9,
    parameter int CLK_DIV      = 4,
    parameter int GUARD_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic rdy_i,
    input  logic miso_i,
    output logic cs_n_o,
    output logic sck_o,
    output logic mosi_o,
    output logic busy_o,
    output logic done_o,
    output logic restart_o
);
    localparam int PAD_HI      = 2;
    localparam int PAD_LO      = 13;
    localparam int FRAME_BYTES = (8 + PAD_HI + ADDR_W + PAD_LO) / 8;
    localparam int IDX_W       = (FRAME_BYTES > 2) ? $clog2(FRAME_BYTES) : 1;

    logic              tx_load, tx_done, tx_busy;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] blk;
    logic [7:0]        tx_byte;
    logic              unused_miso;

    assign unused_miso = miso_i;

    erase_walk_ctrl #(
        .BLOCK_COUNT (BLOCK_COUNT),
        .ADDR_W      (ADDR_W),
        .FRAME_BYTES (FRAME_BYTES),
        .GUARD_CYCLES(GUARD_CYCLES)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .rdy_i    (rdy_i),
        .tx_done_i(tx_done),
        .tx_load_o(tx_load),
        .idx_o    (idx),
        .blk_o    (blk),
        .cs_n_o   (cs_n_o),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .restart_o(restart_o)
    );

    erase_frame_bytes #(
        .ADDR_W(ADDR_W),
        .PAD_HI(PAD_HI),
        .PAD_LO(PAD_LO)
    ) frame_i (
        .blk_i (blk),
        .idx_i (idx),
        .byte_o(tx_byte)
    );

    spi_mode3_tx #(
        .CLK_DIV(CLK_DIV)
    ) tx_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(tx_load),
        .byte_i(tx_byte),
        .busy_o(tx_busy),
        .done_o(tx_done),
        .sck_o (sck_o),
        .mosi_o(mosi_o)
    );

    // R3: chip select is held low whenever a byte is on the wire.
    a_r3_cs_low_while_shifting: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> !cs_n_o);

    // R4: the serial clock is high whenever chip select is high.
    a_r4_sck_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> sck_o);
endmodule

// File: tb/flash_erase_walker_tb_top.sv
module flash_erase_walker_tb_top;
    localparam int NBLK  = 6;
    localparam int GUARD = 2;

    logic clk = 1'b0;
    logic rst_n, start_i, rdy_i, miso_i;
    logic cs_n_o, sck_o, mosi_o, busy_o, done_o, restart_o;

    int checks = 0;
    int errors = 0;

    // Flash model and monitor state.
    int          mode = 0;
    int          frames, exp_blk, bitcnt, low_run, gap_cnt, busy_left;
    int          restarts = 0, dones = 0;
    logic [31:0] shreg;
    logic        prev_cs = 1'b1, prev_sck = 1'b1, prev_mosi = 1'b0, prev_done = 1'b0;

    always #5 clk = ~clk;

    flash_erase_walker #(
        .BLOCK_COUNT (NBLK),
        .ADDR_W      (9),
        .CLK_DIV     (4),
        .GUARD_CYCLES(GUARD)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rdy_i(rdy_i), .miso_i(miso_i),
        .cs_n_o(cs_n_o), .sck_o(sck_o), .mosi_o(mosi_o), .busy_o(busy_o),
        .done_o(done_o), .restart_o(restart_o)
    );

    function automatic logic [31:0] exp_frame(int b);
        logic [8:0] a = 9'(b);
        return {8'h50, 2'b00, a, 13'h0};
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: decodes the SPI wire, models ready/busy and randomizes MISO.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cs_n_o && !prev_sck && sck_o) begin
                shreg  = {shreg[30:0], mosi_o};
                bitcnt = bitcnt + 1;
            end
            if (!cs_n_o && sck_o && (mosi_o !== prev_mosi))
                chk(0, "R4 mosi moved while sck high", mosi_o, prev_mosi);
            if (cs_n_o && !sck_o)
                chk(0, "R4 sck idle level", sck_o, 1);
            if (!sck_o) low_run = low_run + 1;
            else if (!prev_sck) begin
                chk(low_run == 2, "R4 sck low half", low_run, 2);
                low_run = 0;
            end
            if (prev_cs && !cs_n_o) begin
                chk(rdy_i == 1'b1, "R6 frame while busy", rdy_i, 1);
                chk(sck_o == 1'b1, "R4 sck high at cs fall", sck_o, 1);
                if (frames > 0) chk(gap_cnt >= GUARD, "R6 guard gap", gap_cnt, GUARD);
                bitcnt = 0;
            end else if (!prev_cs && cs_n_o) begin
                chk(bitcnt == 32, "R3 bits per frame", bitcnt, 32);
                chk(shreg == exp_frame(exp_blk), "R3/R5 frame content", shreg, exp_frame(exp_blk));
                exp_blk = exp_blk + 1;
                frames  = frames + 1;
                gap_cnt = 0;
                if (mode == 1) busy_left = 0;
                else if (mode == 2) busy_left = 60 + int'($urandom_range(0, 40));
                else busy_left = int'($urandom_range(0, 30));
                rdy_i = (busy_left == 0);
            end else if (cs_n_o) begin
                gap_cnt = gap_cnt + 1;
                if (busy_left > 0) begin
                    busy_left = busy_left - 1;
                    if (busy_left == 0) rdy_i = 1'b1;
                end
            end
            if (restart_o) restarts = restarts + 1;
            if (done_o) begin
                dones = dones + 1;
                chk(!busy_o, "R7 busy low at done", busy_o, 0);
                chk(frames == NBLK, "R7 frames at done", frames, NBLK);
                if (prev_done) chk(0, "R7 done width", 2, 1);
            end
            miso_i = 1'($urandom);
        end
        prev_cs   = cs_n_o;
        prev_sck  = sck_o;
        prev_mosi = mosi_o;
        prev_done = done_o;
    end

    task automatic run_walk(int m, bit poke);
        int r0, d0;
        bit seen;
        @(negedge clk);
        mode = m; frames = 0; exp_blk = 0; low_run = 0; gap_cnt = 0;
        r0 = restarts; d0 = dones;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(restart_o == 1'b1, "R2 restart pulse", restart_o, 1);
        chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
        @(negedge clk);
        chk(restart_o == 1'b0, "R2 restart one clock", restart_o, 0);
        if (poke) begin
            while (frames < 2) @(negedge clk);
            start_i = 1'b1;
            repeat (3) @(negedge clk);
            start_i = 1'b0;
        end
        seen = 0;
        for (int i = 0; i < 40000 && !seen; i++) begin
            @(negedge clk);
            if (dones != d0) seen = 1;
        end
        chk(seen, "R7 done observed", seen, 1);
        repeat (30) @(negedge clk);
        chk(frames == NBLK, "R5 one frame per block", frames, NBLK);
        chk(dones == d0 + 1, "R7 single done", dones - d0, 1);
        chk(restarts == r0 + 1, "R8 start ignored while busy", restarts - r0, 1);
        chk(cs_n_o && sck_o && !busy_o, "R7 idle after walk", {cs_n_o, sck_o, busy_o}, 3'b110);
    endtask

    initial begin
        void'($urandom(32'd1177));
        rst_n = 1'b0; start_i = 1'b0; rdy_i = 1'b1; miso_i = 1'b0;
        frames = 0; exp_blk = 0; bitcnt = 0; low_run = 0; gap_cnt = 0; busy_left = 0;
        shreg = '0;
        repeat (4) @(negedge clk);
        chk(cs_n_o == 1'b1, "R1 cs_n in reset", cs_n_o, 1);
        chk(sck_o == 1'b1, "R1 sck in reset", sck_o, 1);
        chk(!busy_o && !done_o && !restart_o, "R1 strobes in reset", {busy_o, done_o, restart_o}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(cs_n_o && sck_o && !busy_o, "R1 idle after reset", {cs_n_o, sck_o, busy_o}, 3'b110);
        run_walk(0, 1'b1);   // random erase times, R8 poke, R9 random MISO
        run_walk(1, 1'b0);   // device never drops ready: guard alone, R6
        run_walk(2, 1'b0);   // long erase times
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule